// File: doc/BRIEF.md
# Configurable Pipelined Integer Multiplier

This block forms the exact product of two operands of equal width. The result has twice the operand width, so it never overflows. A compile-time parameter chooses the arithmetic. In one mode both operands and the result are two's-complement numbers. In the other mode all three are plain unsigned numbers. The choice cannot change while the block runs.

A second parameter sets how many register stages lie between the operands and the product. A deeper pipeline shortens the logic between registers, so the block can run at a higher clock rate, but each result takes longer to arrive. One active-high enable moves every stage forward together. While the enable is low, the whole pipeline stays as it is. A synchronous active-high reset clears every stage.

The operands are registered at the input and the multiplication happens right after that input register. Any further stages delay the product. With a depth of one, the only register holds the product of the unregistered inputs.

Top module: `mulpipe_top`

## Requirements
- R1: `prod` is the exact full-width (2*DW bit) product of the operand pair captured LEVELS enabled edges earlier, for every operand value.
- R2: With MODE = ARITH_SIGNED, operands and product are two's complement: with DW=16, 0xA92F times 0x712C gives 0xD99ED314, 0xFFFF times 0xFFFF gives 0x00000001, and 0x8000 times 0x7FFF gives 0xC0008000.
- R3: With MODE = ARITH_UNSIGNED, operands are zero-extended: with DW=16, 0xFFFF times 0xFFFF gives 0xFFFE0001, and 0xA92F times 0x712C gives 0x4ACAD314.
- R4: Latency is exactly LEVELS enabled rising edges, counting the edge that captures the operands. With LEVELS=3, a pair captured at edge n appears on `prod` after edge n+2 and is replaced after edge n+3.
- R5: While `en` is low, `prod` holds its value and the operand inputs are ignored. When `en` returns high, the results already in the pipeline come out in order, with none lost and none repeated.
- R6: While `rst` is high at a rising edge, every stage is cleared, so `prod` reads zero after that edge. Products that were in the pipeline before the reset never appear afterwards.
- R7: With LEVELS=1, the product of the operands present at an enabled edge appears on `prod` immediately after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, clears all stages |
| en | input | 1 | Pipeline advance enable, active high |
| a_in | input | DW | First operand |
| b_in | input | DW | Second operand |
| prod | output | 2*DW | Full-precision product |

## Verification
The bench aims at the operand values where extension errors show up. These are the most negative value, all ones, and mixed signs. A design that extended an operand the wrong way would give 0xFFFE0001 instead of 0x00000001 for all-ones squared in signed mode. It would give a wrong high half in unsigned mode. The enable tests stop the pipeline in the middle of a stream. A stage that ignores the enable would lose a result or output one twice, so the resumed results would arrive early or repeat. Single-pulse and mid-stream reset tests catch an extra or missing stage, because the result would land one edge off. They also catch a stage that reset does not clear, because an old product would reappear.

// File: rtl/mulpipe_pkg.sv
package mulpipe_pkg;

    typedef enum logic {
        ARITH_UNSIGNED = 1'b0,
        ARITH_SIGNED   = 1'b1
    } arith_e;

    // Bit used to fill the upper half of a widened operand
    function automatic logic fill_bit(input arith_e mode, input logic msb);
        return (mode == ARITH_SIGNED) ? msb : 1'b0;
    endfunction

    // Operand register at the input when the depth allows one
    function automatic int front_stages(input int levels);
        return (levels > 1) ? 1 : 0;
    endfunction

endpackage

// File: rtl/mulpipe_extend.sv
module mulpipe_extend
    import mulpipe_pkg::*;
#(
    parameter int     DW   = 16,
    parameter arith_e MODE = ARITH_SIGNED
) (
    input  logic [DW-1:0]   raw,
    output logic [2*DW-1:0] wide
);
    localparam int PW = 2 * DW;

    logic fill;

    assign fill = fill_bit(MODE, raw[DW-1]);
    assign wide = {{DW{fill}}, raw};

    logic [PW-1:0] unused_chk;
    assign unused_chk = wide;
endmodule

// File: rtl/mulpipe_front.sv
module mulpipe_front
    import mulpipe_pkg::*;
#(
    parameter int     DW      = 16,
    parameter arith_e MODE    = ARITH_SIGNED,
    parameter int     IN_REGS = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic [DW-1:0]   a_raw,
    input  logic [DW-1:0]   b_raw,
    output logic [2*DW-1:0] product
);
    localparam int PW = 2 * DW;

    logic [DW-1:0] a_cap;
    logic [DW-1:0] b_cap;
    logic [PW-1:0] a_wide;
    logic [PW-1:0] b_wide;

    generate
        if (IN_REGS > 0) begin : g_capture
            always_ff @(posedge clk) begin
                if (rst) begin
                    a_cap <= '0;
                    b_cap <= '0;
                end else if (en) begin
                    a_cap <= a_raw;
                    b_cap <= b_raw;
                end
            end
        end else begin : g_direct
            assign a_cap = a_raw;
            assign b_cap = b_raw;
        end
    endgenerate

    mulpipe_extend #(.DW(DW), .MODE(MODE)) u_ext_a (.raw(a_cap), .wide(a_wide));
    mulpipe_extend #(.DW(DW), .MODE(MODE)) u_ext_b (.raw(b_cap), .wide(b_wide));

    // Both factors are widened to PW bits, so the low PW bits are exact
    assign product = a_wide * b_wide;
endmodule

// File: rtl/mulpipe_tail.sv
module mulpipe_tail #(
    parameter int W     = 32,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [DEPTH];

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_stage
            logic [W-1:0] nxt;
            if (s == 0) begin : g_head
                assign nxt = d;
            end else begin : g_link
                assign nxt = stg[s-1];
            end
            always_ff @(posedge clk) begin
                if (rst) begin
                    stg[s] <= '0;
                end else if (en) begin
                    stg[s] <= nxt;
                end
            end
        end
    endgenerate

    assign q = stg[DEPTH-1];
endmodule

// File: rtl/mulpipe_top.sv
module mulpipe_top
    import mulpipe_pkg::*;
#(
    parameter int     DW     = 16,
    parameter int     LEVELS = 3,
    parameter arith_e MODE   = ARITH_SIGNED
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic [DW-1:0]   a_in,
    input  logic [DW-1:0]   b_in,
    output logic [2*DW-1:0] prod
);
    localparam int PW         = 2 * DW;
    localparam int IN_REGS    = front_stages(LEVELS);
    localparam int TAIL_DEPTH = LEVELS - IN_REGS;

    logic [PW-1:0] raw_product;

    mulpipe_front #(
        .DW     (DW),
        .MODE   (MODE),
        .IN_REGS(IN_REGS)
    ) u_front (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .a_raw  (a_in),
        .b_raw  (b_in),
        .product(raw_product)
    );

    mulpipe_tail #(
        .W    (PW),
        .DEPTH(TAIL_DEPTH)
    ) u_tail (
        .clk(clk),
        .rst(rst),
        .en (en),
        .d  (raw_product),
        .q  (prod)
    );
endmodule

// File: rtl/mulpipe_chk.sv
module mulpipe_chk
    import mulpipe_pkg::*;
#(
    parameter int     DW     = 16,
    parameter int     LEVELS = 3,
    parameter arith_e MODE   = ARITH_SIGNED
) (
    input logic            clk,
    input logic            rst,
    input logic            en,
    input logic [DW-1:0]   a_in,
    input logic [DW-1:0]   b_in,
    input logic [2*DW-1:0] prod
);
    localparam int PW = 2 * DW;

    function automatic logic [PW-1:0] widen(input logic [DW-1:0] v);
        if (MODE == ARITH_SIGNED) return {{DW{v[DW-1]}}, v};
        return {{DW{1'b0}}, v};
    endfunction

    // Reference pipeline advanced by the same enable
    logic [PW-1:0] ref_q [LEVELS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LEVELS; i++) ref_q[i] <= '0;
        end else if (en) begin
            ref_q[0] <= widen(a_in) * widen(b_in);
            for (int i = 1; i < LEVELS; i++) ref_q[i] <= ref_q[i-1];
        end
    end

    // R1 / R4: product matches reference after LEVELS enabled edges
    p_exact_product_r1: assert property (@(posedge clk) disable iff (rst)
        prod == ref_q[LEVELS-1]);

    p_freeze_r5: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(prod));

    p_reset_clear_r6: assert property (@(posedge clk)
        rst |=> (prod == '0));

    p_known_out_r1: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(prod));

    generate
        if (LEVELS == 1) begin : g_single
            p_single_stage_r7: assert property (@(posedge clk) disable iff (rst)
                en |=> (prod == ($past(widen(a_in)) * $past(widen(b_in)))));
        end
    endgenerate
endmodule

bind mulpipe_top mulpipe_chk #(
    .DW    (DW),
    .LEVELS(LEVELS),
    .MODE  (MODE)
) chk_i (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .a_in(a_in),
    .b_in(b_in),
    .prod(prod)
);

// File: tb/mulpipe_top_tb_top.sv
module mulpipe_top_tb_top;
    import mulpipe_pkg::*;

    localparam int DW = 16;
    localparam int LS = 3;

    typedef struct packed {
        logic [15:0] a;
        logic [15:0] b;
        logic [31:0] es;
        logic [31:0] eu;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{16'hA92F, 16'h712C, 32'hD99ED314, 32'h4ACAD314},
        '{16'hFFFF, 16'hFFFF, 32'h00000001, 32'hFFFE0001},
        '{16'h8000, 16'h8000, 32'h40000000, 32'h40000000},
        '{16'h8000, 16'h7FFF, 32'hC0008000, 32'h3FFF8000},
        '{16'h0000, 16'h1234, 32'h00000000, 32'h00000000},
        '{16'h0003, 16'h0005, 32'h0000000F, 32'h0000000F},
        '{16'hFFFF, 16'h0002, 32'hFFFFFFFE, 32'h0001FFFE},
        '{16'h7FFF, 16'h7FFF, 32'h3FFF0001, 32'h3FFF0001}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en  = 1'b0;
    logic [DW-1:0] a   = '0;
    logic [DW-1:0] b   = '0;
    logic [31:0]   prod_s;
    logic [31:0]   prod_u;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic [31:0] ms [LS];
    logic [31:0] mu;

    always #5 clk = ~clk;

    mulpipe_top #(.DW(DW), .LEVELS(LS), .MODE(ARITH_SIGNED)) dut_i (
        .clk(clk), .rst(rst), .en(en), .a_in(a), .b_in(b), .prod(prod_s));

    mulpipe_top #(.DW(DW), .LEVELS(1), .MODE(ARITH_UNSIGNED)) dut_u_i (
        .clk(clk), .rst(rst), .en(en), .a_in(a), .b_in(b), .prod(prod_u));

    function automatic logic [31:0] ref_s(input logic [15:0] x, input logic [15:0] y);
        return {{16{x[15]}}, x} * {{16{y[15]}}, y};
    endfunction

    function automatic logic [31:0] ref_u(input logic [15:0] x, input logic [15:0] y);
        return {16'h0, x} * {16'h0, y};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at negedge, clock one edge, update model, return at negedge
    task automatic step(input logic r, input logic e, input logic [15:0] x, input logic [15:0] y);
        rst = r; en = e; a = x; b = y;
        @(posedge clk);
        if (r) begin
            for (int i = 0; i < LS; i++) ms[i] = '0;
            mu = '0;
        end else if (e) begin
            for (int i = LS - 1; i > 0; i--) ms[i] = ms[i-1];
            ms[0] = ref_s(x, y);
            mu    = ref_u(x, y);
        end
        @(negedge clk);
    endtask

    task automatic model_chk();
        chk("R1 signed stream vs model", prod_s, ms[LS-1]);
        chk("R7 unsigned single stage vs model", prod_u, mu);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] held_s;
        logic [31:0] held_u;
        @(negedge clk);

        // R6: reset state
        step(1'b1, 1'b0, 16'h0, 16'h0);
        step(1'b1, 1'b1, 16'h1234, 16'h5678);
        chk("R6 reset signed", prod_s, 32'h0);
        chk("R6 reset unsigned", prod_u, 32'h0);

        // Table walk: R3 and R7 on the unsigned one-stage unit, R2 two edges late
        for (int i = 0; i < 8; i++) begin
            step(1'b0, 1'b1, VECS[i].a, VECS[i].b);
            chk("R3 unsigned table", prod_u, VECS[i].eu);
            if (i >= 2) chk("R2 signed table", prod_s, VECS[i-2].es);
            model_chk();
        end
        step(1'b0, 1'b1, 16'h0, 16'h0);
        chk("R2 signed table", prod_s, VECS[6].es);
        step(1'b0, 1'b1, 16'h0, 16'h0);
        chk("R2 signed table", prod_s, VECS[7].es);

        // R4: single pulse latency
        step(1'b0, 1'b1, 16'h0, 16'h0);
        step(1'b0, 1'b1, 16'hA92F, 16'h712C);
        chk("R4 edge1", prod_s, 32'h0);
        step(1'b0, 1'b1, 16'h0, 16'h0);
        chk("R4 edge2", prod_s, 32'h0);
        step(1'b0, 1'b1, 16'h0, 16'h0);
        chk("R4 edge3", prod_s, 32'hD99ED314);
        step(1'b0, 1'b1, 16'h0, 16'h0);
        chk("R4 edge4", prod_s, 32'h0);

        // R5: freeze mid-stream
        step(1'b0, 1'b1, 16'hA92F, 16'h712C);
        step(1'b0, 1'b1, 16'hFFFF, 16'h0002);
        held_s = prod_s;
        held_u = prod_u;
        chk("R5 unsigned before freeze", held_u, 32'h0001FFFE);
        for (int k = 0; k < 4; k++) begin
            step(1'b0, 1'b0, 16'(k * 16'h3131 + 16'h0101), 16'hBEEF);
            chk("R5 frozen signed", prod_s, held_s);
            chk("R5 frozen unsigned", prod_u, held_u);
        end
        step(1'b0, 1'b1, 16'h0, 16'h0);
        chk("R5 resume first", prod_s, 32'hD99ED314);
        step(1'b0, 1'b1, 16'h0, 16'h0);
        chk("R5 resume second", prod_s, 32'hFFFFFFFE);
        step(1'b0, 1'b1, 16'h0, 16'h0);
        chk("R5 resume third", prod_s, 32'h0);

        // R6: reset mid-flight
        step(1'b0, 1'b1, 16'h7FFF, 16'h7FFF);
        step(1'b0, 1'b1, 16'h8000, 16'h8000);
        step(1'b1, 1'b1, 16'hFFFF, 16'hFFFF);
        chk("R6 midflight signed", prod_s, 32'h0);
        chk("R6 midflight unsigned", prod_u, 32'h0);
        for (int k = 0; k < 3; k++) begin
            step(1'b0, 1'b1, 16'h0, 16'h0);
            chk("R6 no stale product", prod_s, 32'h0);
        end

        // R1: randomized stream with random enable and corner operands
        for (int k = 0; k < 400; k++) begin
            logic [15:0] x;
            logic [15:0] y;
            logic [1:0]  pick;
            x = 16'($urandom);
            y = 16'($urandom);
            pick = 2'($urandom);
            if (pick == 2'd0) x = 16'h8000;
            if (pick == 2'd1) y = 16'hFFFF;
            step(1'b0, ($urandom % 4) != 0, x, y);
            model_chk();
        end

        finish_run();
    end
endmodule